// File: doc/BRIEF.md
# Fast Ethernet PCS Transmit Path

This block is the transmit half of the physical coding sublayer for a 100 Mb/s twisted-pair link. It runs on the 125 MHz serial clock. Once every five serial clocks it raises a nibble strobe, and in the same cycle the MAC side presents a 4-bit nibble with its enable and error flags. The block turns each nibble slot into a 5-bit code group. It inserts the start and end delimiters of a frame and fills the gaps between frames with idle groups. It shifts each group out one bit per clock, most significant bit first, XORs the bit stream with an 11-bit scrambler key stream, and drives the result as a three-level MLT-3 symbol on a 2-bit signed output.

A raw mode lets a test or line-conditioning source feed scrambled 5-bit words straight to the line coder. Each word is formed from the error flag, which becomes the top bit, and the four data bits. The enable flag is ignored in this mode. Raw mode can only take hold while auto-negotiation is reported off. Analog pulse shaping, the line driver and auto-negotiation itself belong to other blocks.

Top module: `fe_pcs_tx`

## Requirements
- R1: In a data slot (enable high and error low, after the two start delimiters) the nibble maps to its code group as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R2: While rst_n is low, line_sym is 0 and nib_take is low. The group being sent when reset ends is IDLE (11111), and the scrambler state restarts from SCR_SEED.
- R3: Outside a frame and its end sequence, a slot with the enable low produces IDLE 11111. The error flag has no effect in such a slot.
- R4: The first two slots after the enable rises produce J (11000) and then K (10001), whatever the nibble holds.
- R5: The first slot with the enable low after J or data produces T (01101). The slot after T always produces R (00111), even if the enable is high, and framing then returns to idle.
- R6: A data slot with the error flag high produces HALT (00100).
- R7: The scrambler state register starts at SCR_SEED and advances on every serial clock. Each step produces a key bit equal to the XOR of state bits 10 and 8 (the taps of x^11 + x^9 + 1). That bit is shifted in at bit 0, and in normal mode it is XORed onto the serial bit.
- R8: nib_take is high for one clock in every five. The slot's inputs are sampled on the clock edge that ends that cycle, and the resulting group is sent over the next five clocks with bit 4 first.
- R9: Each scrambled 1 bit moves the line one step through the cycle 0, +1, 0, -1, starting at 0 and going to +1 first. Each 0 bit holds the level. The step shows on line_sym one clock after the bit is shifted.
- R10: When raw_mode_req is high and autoneg_on is low, the slot sends {mii_txer, mii_txd} unscrambled, and the enable has no effect. Framing restarts at idle, so the first enabled slot afterwards produces J.
- R11: While autoneg_on is high, raw_mode_req has no effect and normal framing and scrambling apply.
- R12: line_sym encodes +1 as 2'b01, 0 as 2'b00 and -1 as 2'b11, and never shows 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_txd | input | 4 | Transmit nibble |
| mii_txen | input | 1 | Transmit enable (frame in progress) |
| mii_txer | input | 1 | Transmit error, top bit of the raw word in raw mode |
| raw_mode_req | input | 1 | Requests raw 5-bit word mode |
| autoneg_on | input | 1 | Auto-negotiation is enabled, which blocks raw mode |
| nib_take | output | 1 | Strobe: nibble inputs are sampled at the end of this cycle |
| line_sym | output | 2 | Signed MLT-3 line level |

## Verification
The bench builds the block with SCR_SEED set to 11'h5A3 instead of the all-ones default, so a design that ignored the seed parameter or stepped the key stream out of phase would mis-decode from the first group. With that seed, the bench recovers each bit from the level changes on line_sym, strips the key stream with its own model of the polynomial, and compares whole code groups. This covers every nibble value, both delimiter pairs, an aborted frame, HALT, a mid-frame switch into raw mode, and a raw request blocked by auto-negotiation.

// File: rtl/fe_pcs_pkg.sv
package fe_pcs_pkg;
  localparam int NIB_W = 4;
  localparam int GRP_W = 5;

  typedef logic [GRP_W-1:0] grp_t;

  localparam grp_t GRP_IDLE = 5'b11111;
  localparam grp_t GRP_J    = 5'b11000;
  localparam grp_t GRP_K    = 5'b10001;
  localparam grp_t GRP_T    = 5'b01101;
  localparam grp_t GRP_R    = 5'b00111;
  localparam grp_t GRP_HALT = 5'b00100;

  typedef enum logic [1:0] {FR_IDLE, FR_SSD2, FR_DATA, FR_ESD2} frm_state_t;

  // 4B/5B data mapping
  function automatic grp_t nib_to_grp(input logic [NIB_W-1:0] nib);
    case (nib)
      4'h0: return 5'b11110;
      4'h1: return 5'b01001;
      4'h2: return 5'b10100;
      4'h3: return 5'b10101;
      4'h4: return 5'b01010;
      4'h5: return 5'b01011;
      4'h6: return 5'b01110;
      4'h7: return 5'b01111;
      4'h8: return 5'b10010;
      4'h9: return 5'b10011;
      4'hA: return 5'b10110;
      4'hB: return 5'b10111;
      4'hC: return 5'b11010;
      4'hD: return 5'b11011;
      4'hE: return 5'b11100;
      default: return 5'b11101;
    endcase
  endfunction

  // MLT-3 phase index to signed line level: 0, +1, 0, -1
  function automatic logic signed [1:0] mlt3_level(input logic [1:0] idx);
    case (idx)
      2'd1: return 2'sb01;
      2'd3: return 2'sb11;
      default: return 2'sb00;
    endcase
  endfunction
endpackage

// File: rtl/fe_pcs_framer.sv
module fe_pcs_framer
  import fe_pcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             raw_mode,
  input  logic             en,
  input  logic             er,
  input  logic [NIB_W-1:0] nib,
  output grp_t             grp
);
  frm_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    grp  = GRP_IDLE;
    if (raw_mode) begin
      grp  = {er, nib};
      st_d = FR_IDLE;
    end else begin
      case (st_q)
        FR_IDLE: begin
          if (en) begin
            grp  = GRP_J;
            st_d = FR_SSD2;
          end
        end
        FR_SSD2: begin
          if (en) begin
            grp  = GRP_K;
            st_d = FR_DATA;
          end else begin
            grp  = GRP_T;
            st_d = FR_ESD2;
          end
        end
        FR_DATA: begin
          if (en) begin
            grp = er ? GRP_HALT : nib_to_grp(nib);
          end else begin
            grp  = GRP_T;
            st_d = FR_ESD2;
          end
        end
        default: begin
          grp  = GRP_R;
          st_d = FR_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= FR_IDLE;
    else if (load) st_q <= st_d;
  end
endmodule

// File: rtl/fe_pcs_serializer.sv
module fe_pcs_serializer
  import fe_pcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  grp_t grp_in,
  input  logic raw_in,
  output logic load,
  output logic nrz_bit,
  output logic raw_q
);
  localparam int PH_W = $clog2(GRP_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GRP_W - 1);

  logic [PH_W-1:0] phase_q;
  grp_t            shreg_q;

  assign load    = (phase_q == PH_LAST);
  assign nrz_bit = shreg_q[GRP_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      shreg_q <= GRP_IDLE;
      raw_q   <= 1'b0;
    end else if (load) begin
      phase_q <= '0;
      shreg_q <= grp_in;
      raw_q   <= raw_in;
    end else begin
      phase_q <= phase_q + 1'b1;
      shreg_q <= {shreg_q[GRP_W-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/fe_pcs_scrambler.sv
module fe_pcs_scrambler #(
  parameter int              SCR_W  = 11,
  parameter int              TAP_A  = 11,
  parameter int              TAP_B  = 9,
  parameter logic [SCR_W-1:0] SEED  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nrz_bit,
  input  logic             bypass,
  output logic             tx_bit,
  output logic [SCR_W-1:0] state
);
  function automatic logic key_of(input logic [SCR_W-1:0] s);
    return s[TAP_A-1] ^ s[TAP_B-1];
  endfunction

  logic key;
  assign key    = key_of(state);
  assign tx_bit = nrz_bit ^ (key & ~bypass);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[SCR_W-2:0], key};
  end
endmodule

// File: rtl/fe_pcs_mlt3.sv
module fe_pcs_mlt3
  import fe_pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_bit,
  output logic signed [1:0] level
);
  logic [1:0] idx_q;

  assign level = mlt3_level(idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= 2'd0;
    else if (tx_bit) idx_q <= idx_q + 2'd1;
  end
endmodule

// File: rtl/fe_pcs_tx.sv
module fe_pcs_tx
  import fe_pcs_pkg::*;
#(
  parameter int               SCR_W     = 11,
  parameter int               SCR_TAP_A = 11,
  parameter int               SCR_TAP_B = 9,
  parameter logic [SCR_W-1:0] SCR_SEED  = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mii_txd,
  input  logic              mii_txen,
  input  logic              mii_txer,
  input  logic              raw_mode_req,
  input  logic              autoneg_on,
  output logic              nib_take,
  output logic signed [1:0] line_sym
);
  logic             raw_eff;
  logic             load;
  logic             nrz_bit;
  logic             raw_q;
  logic             tx_bit;
  logic [SCR_W-1:0] scr_state;
  grp_t             grp;

  assign raw_eff  = raw_mode_req & ~autoneg_on;
  assign nib_take = load;

  fe_pcs_framer u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .raw_mode (raw_eff),
    .en       (mii_txen),
    .er       (mii_txer),
    .nib      (mii_txd),
    .grp      (grp)
  );

  fe_pcs_serializer u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .grp_in  (grp),
    .raw_in  (raw_eff),
    .load    (load),
    .nrz_bit (nrz_bit),
    .raw_q   (raw_q)
  );

  fe_pcs_scrambler #(
    .SCR_W (SCR_W),
    .TAP_A (SCR_TAP_A),
    .TAP_B (SCR_TAP_B),
    .SEED  (SCR_SEED)
  ) u_scr (
    .clk     (clk),
    .rst_n   (rst_n),
    .nrz_bit (nrz_bit),
    .bypass  (raw_q),
    .tx_bit  (tx_bit),
    .state   (scr_state)
  );

  fe_pcs_mlt3 u_mlt3 (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_bit (tx_bit),
    .level  (line_sym)
  );
endmodule

// File: rtl/fe_pcs_tx_chk.sv
module fe_pcs_tx_chk
  import fe_pcs_pkg::*;
#(
  parameter int SCR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic signed [1:0] line_sym,
  input logic              nib_take,
  input logic              tx_bit,
  input logic [SCR_W-1:0]  scr_state,
  input logic              raw_eff,
  input logic              raw_mode_req,
  input logic              autoneg_on
);
  localparam int CW = $clog2(GRP_W);
  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cyc_q <= '0;
    else if (cyc_q == CW'(GRP_W - 1))    cyc_q <= '0;
    else                                 cyc_q <= cyc_q + 1'b1;
  end

  a_r12_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    line_sym != 2'sb10);

  a_r9_no_rail_jump_up: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sym == 2'sb11) |=> (line_sym != 2'sb01));

  a_r9_no_rail_jump_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sym == 2'sb01) |=> (line_sym != 2'sb11));

  a_r9_one_steps: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit |=> !$stable(line_sym));

  a_r9_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit |=> $stable(line_sym));

  a_r8_take_slot: assert property (@(posedge clk) disable iff (!rst_n)
    nib_take |-> (cyc_q == CW'(GRP_W - 1)));

  a_r8_take_due: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CW'(GRP_W - 1)) |-> nib_take);

  a_r7_scr_live: assert property (@(posedge clk) disable iff (!rst_n)
    scr_state != '0);

  a_r11_an_blocks_raw: assert property (@(posedge clk) disable iff (!rst_n)
    autoneg_on |-> !raw_eff);

  a_r10_raw_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    raw_eff |-> raw_mode_req);
endmodule

bind fe_pcs_tx fe_pcs_tx_chk #(.SCR_W(SCR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .line_sym     (line_sym),
  .nib_take     (nib_take),
  .tx_bit       (tx_bit),
  .scr_state    (scr_state),
  .raw_eff      (raw_eff),
  .raw_mode_req (raw_mode_req),
  .autoneg_on   (autoneg_on)
);

// File: tb/fe_pcs_tx_tb.sv
module fe_pcs_tx_tb;
  localparam int          CLK_PERIOD = 8;
  localparam logic [10:0] TB_SEED    = 11'h5A3;

  typedef struct packed {
    logic       en;
    logic       er;
    logic [3:0] d;
    logic       byp;
    logic       an;
    logic [4:0] exp;
    logic [3:0] req;
  } row_t;

  localparam int NROW = 38;
  localparam row_t ROWS [NROW] = '{
    '{1'b0,1'b0,4'h0,1'b0,1'b0,5'b11111,4'd3},  // R3 idle
    '{1'b1,1'b0,4'h5,1'b0,1'b0,5'b11000,4'd4},  // R4 J
    '{1'b1,1'b0,4'h5,1'b0,1'b0,5'b10001,4'd4},  // R4 K
    '{1'b1,1'b0,4'h0,1'b0,1'b0,5'b11110,4'd1},  // R1
    '{1'b1,1'b0,4'h1,1'b0,1'b0,5'b01001,4'd1},
    '{1'b1,1'b0,4'h2,1'b0,1'b0,5'b10100,4'd1},
    '{1'b1,1'b0,4'h7,1'b0,1'b0,5'b01111,4'd1},
    '{1'b1,1'b0,4'h8,1'b0,1'b0,5'b10010,4'd1},
    '{1'b1,1'b0,4'hB,1'b0,1'b0,5'b10111,4'd1},
    '{1'b1,1'b0,4'hC,1'b0,1'b0,5'b11010,4'd1},
    '{1'b1,1'b1,4'h3,1'b0,1'b0,5'b00100,4'd6},  // R6 halt
    '{1'b1,1'b0,4'hE,1'b0,1'b0,5'b11100,4'd1},
    '{1'b0,1'b0,4'h0,1'b0,1'b0,5'b01101,4'd5},  // R5 T
    '{1'b0,1'b0,4'h0,1'b0,1'b0,5'b00111,4'd5},  // R5 R
    '{1'b0,1'b1,4'h9,1'b0,1'b0,5'b11111,4'd3},  // R3 er ignored
    '{1'b1,1'b0,4'h0,1'b0,1'b0,5'b11000,4'd4},
    '{1'b0,1'b0,4'h0,1'b0,1'b0,5'b01101,4'd5},  // R5 abort after J
    '{1'b1,1'b0,4'h4,1'b0,1'b0,5'b00111,4'd5},  // R5 R despite en
    '{1'b1,1'b0,4'h4,1'b0,1'b0,5'b11000,4'd4},
    '{1'b1,1'b0,4'h4,1'b0,1'b0,5'b10001,4'd4},
    '{1'b1,1'b0,4'hF,1'b0,1'b0,5'b11101,4'd1},
    '{1'b1,1'b0,4'h3,1'b0,1'b0,5'b10101,4'd1},
    '{1'b1,1'b0,4'h4,1'b0,1'b0,5'b01010,4'd1},
    '{1'b1,1'b0,4'h6,1'b0,1'b0,5'b01110,4'd1},
    '{1'b1,1'b0,4'h9,1'b0,1'b0,5'b10011,4'd1},
    '{1'b1,1'b0,4'hA,1'b0,1'b0,5'b10110,4'd1},
    '{1'b1,1'b0,4'hD,1'b0,1'b0,5'b11011,4'd1},
    '{1'b1,1'b0,4'h5,1'b0,1'b0,5'b01011,4'd1},
    '{1'b1,1'b1,4'h6,1'b1,1'b0,5'b10110,4'd10}, // R10 raw mid-frame
    '{1'b0,1'b0,4'h0,1'b1,1'b0,5'b00000,4'd10},
    '{1'b1,1'b1,4'hF,1'b1,1'b0,5'b11111,4'd10},
    '{1'b0,1'b1,4'h1,1'b1,1'b0,5'b10001,4'd10},
    '{1'b1,1'b0,4'h5,1'b1,1'b1,5'b11000,4'd11}, // R11 raw blocked
    '{1'b1,1'b0,4'h5,1'b1,1'b1,5'b10001,4'd11},
    '{1'b1,1'b0,4'h2,1'b0,1'b0,5'b10100,4'd1},
    '{1'b0,1'b0,4'h0,1'b0,1'b0,5'b01101,4'd5},
    '{1'b0,1'b0,4'h0,1'b0,1'b0,5'b00111,4'd5},
    '{1'b0,1'b0,4'h0,1'b0,1'b0,5'b11111,4'd3}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        mii_txd = 4'h0;
  logic              mii_txen = 1'b0;
  logic              mii_txer = 1'b0;
  logic              raw_mode_req = 1'b0;
  logic              autoneg_on = 1'b0;
  logic              nib_take;
  logic signed [1:0] line_sym;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fe_pcs_tx #(.SCR_SEED(TB_SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .mii_txd(mii_txd), .mii_txen(mii_txen),
    .mii_txer(mii_txer), .raw_mode_req(raw_mode_req), .autoneg_on(autoneg_on),
    .nib_take(nib_take), .line_sym(line_sym)
  );

  // expected group stream
  logic [4:0] exp_q [$];
  bit         rawf_q [$];
  int         req_q [$];

  // decoder state
  logic              started = 1'b0;
  logic [10:0]       hist;
  logic signed [1:0] prev_lv;
  logic signed [1:0] last_nz;
  logic [4:0]        gbits, gkeys;
  int                pos;
  int                mlt_err = 0, mlt_steps = 0, bad_code = 0;
  int                take_err = 0, takes = 0, cyc = 0, last_take = -1;
  bit                scr_seen = 1'b0;

  always @(posedge clk) started <= rst_n;

  always @(negedge clk) begin
    if (!(started && rst_n)) begin
      hist = TB_SEED; prev_lv = 2'sb00; last_nz = 2'sb11; pos = 0;
      cyc = 0; last_take = -1;
    end else begin
      logic chg, key;
      logic [4:0] got;
      if (line_sym == 2'sb10) bad_code++;
      chg = (line_sym != prev_lv);
      if (chg) begin
        mlt_steps++;
        if (prev_lv == 2'sb00) begin
          if (line_sym != ((last_nz == 2'sb01) ? 2'sb11 : 2'sb01)) mlt_err++;
          last_nz = line_sym;
        end else if (line_sym != 2'sb00) mlt_err++;
      end
      prev_lv = line_sym;
      // key stream of x^11 + x^9 + 1: newest bit = bit 10 xor bit 8
      key = hist[10] ^ hist[8];
      hist = {hist[9:0], key};
      gbits[4-pos] = chg;
      gkeys[4-pos] = key;
      pos++;
      if (pos == 5) begin
        pos = 0;
        if (exp_q.size() > 0) begin
          logic [4:0] e;
          bit rf;
          int rq;
          e = exp_q.pop_front(); rf = rawf_q.pop_front(); rq = req_q.pop_front();
          got = rf ? gbits : (gbits ^ gkeys);
          if (!rf && gbits != got) scr_seen = 1'b1;
          checks++;
          if (got !== e) begin
            failures++;
            $display("FAIL R%0d group got=%b exp=%b", rq, got, e);
          end
        end
      end
      if (nib_take) begin
        takes++;
        if (last_take >= 0 && cyc - last_take != 5) take_err++;
        last_take = cyc;
      end
      cyc++;
    end
  end

  task automatic put(input row_t r);
    do @(negedge clk); while (!nib_take);
    mii_txen = r.en; mii_txer = r.er; mii_txd = r.d;
    raw_mode_req = r.byp; autoneg_on = r.an;
    exp_q.push_back(r.exp);
    rawf_q.push_back(r.byp & ~r.an);
    req_q.push_back(int'(r.req));
  endtask

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state at the ports
    chk(line_sym == 2'sb00, "R2 line in reset", int'(line_sym), 0);
    chk(nib_take == 1'b0, "R2 take in reset", int'(nib_take), 0);
    exp_q.push_back(5'b11111); rawf_q.push_back(1'b0); req_q.push_back(2); // R2 first group idle
    rst_n = 1'b1;
    for (int i = 0; i < NROW; i++) put(ROWS[i]);
    while (exp_q.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(take_err == 0 && takes > 40, "R8 strobe period", take_err, 0);
    chk(mlt_err == 0 && mlt_steps > 0, "R9 mlt3 order", mlt_err, 0);
    chk(bad_code == 0, "R12 level code", bad_code, 0);
    chk(scr_seen, "R7 scrambling active", int'(scr_seen), 1);
    // R2: reset applied again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    exp_q.delete(); rawf_q.delete(); req_q.delete();
    chk(line_sym == 2'sb00, "R2 line after reset", int'(line_sym), 0);
    chk(nib_take == 1'b0, "R2 take after reset", int'(nib_take), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule